// File: doc/BRIEF.md
# Decade Counter with Nine-Preset and Divide-by-Ten Wave Output

This block is a four-bit decade counter built from two stages that are kept in the
system clock domain: a toggle stage (divide by two) and a five-state stage (divide by five).
Two count inputs are sampled on every system clock. The counter reacts to a high-to-low
transition of an input, not to its level. A mode pin sets the order of the two stages.
With mode low, the toggle stage runs first, and the four outputs give a weighted decimal
digit from 0 to 9. With mode high, the five-state stage runs first and drives the toggle
stage, so the lowest output bit becomes a square wave with 50% duty at one tenth of the
input edge rate.

There are two pairs of synchronous preset pins. When both pins of the zero pair are high,
the digit is forced to zero. When both pins of the nine pair are high, the digit is forced
to nine. The nine pair wins if both pairs are active together. Presets are evaluated on
every clock and take priority over any count edge seen in the same cycle.

All pins are plain level signals with no flow control. There is no data stream at the edge
of this block, so nothing here applies back-pressure.

Top module: `decade_divider`

## Requirements
- R1: When clr0_a and clr0_b are both 1 (and the nine pair is not both 1), cnt_q is 0000 after the next clock edge. A single high zero pin has no effect.
- R2: When set9_a and set9_b are both 1, cnt_q is 1001 after the next clock edge. A single high nine pin has no effect.
- R3: When all four preset pins are 1, cnt_q becomes 1001.
- R4: A preset request overrides a count edge detected in the same cycle.
- R5: cnt_q[3:1] is the five-state stage. Its bits, read from bit 3 down to bit 1, step 000, 001, 010, 011, 100 and then back to 000, one step per edge delivered to it.
- R6: While cnt_q[3] is 1, the next step of the five-state stage keeps cnt_q[1] at 0 and returns the stage to 000.
- R7: With sq_mode = 0, each falling edge of cnt_a toggles cnt_q[0]. A 1-to-0 change of cnt_q[0] steps the five-state stage in the same clock. The result is a binary-weighted digit 0 to 9 (bit 3 has weight 8, bit 0 has weight 1). cnt_bd has no effect in this mode.
- R8: With sq_mode = 0, the tenth falling edge of cnt_a after 0000 takes the digit from 1001 back to 0000. cnt_q never exceeds 1001.
- R9: With sq_mode = 1, each falling edge of cnt_bd steps the five-state stage. A 1-to-0 change of cnt_q[3] toggles cnt_q[0], so cnt_q[0] stays high for five input edges and low for five. cnt_a has no effect in this mode.
- R10: A falling edge is an input sampled 0 on a clock edge after being sampled 1 on the previous edge. cnt_q changes on that same clock edge. A level held high or low causes no change.
- R11: rst_n low asynchronously forces cnt_q to 0000 and clears the edge history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a | input | 1 | Count input of the toggle stage (decimal mode) |
| cnt_bd | input | 1 | Count input of the five-state stage (wave mode) |
| sq_mode | input | 1 | 0 = decimal digit order, 1 = divide-by-ten wave order |
| clr0_a | input | 1 | Zero preset, first pin of the pair |
| clr0_b | input | 1 | Zero preset, second pin of the pair |
| set9_a | input | 1 | Nine preset, first pin of the pair |
| set9_b | input | 1 | Nine preset, second pin of the pair |
| cnt_q | output | 4 | Counter state, bit 0 is the toggle stage |

## Verification
The decimal order is driven with more than ten edges on cnt_a while cnt_bd toggles freely.
This shows that the toggle stage carries into the five-state stage at every odd-to-even step,
that the 9-to-0 wrap happens, and that the unused input is ignored. The wave order is driven
with more than twenty edges on cnt_bd while cnt_a toggles. This separates the wrap of the
five-state stage from the inhibited bit 1 and shows that bit 0 changes only on the 4-to-0
step. Long high and low levels show edge sensitivity as opposed to level sensitivity. Single
preset pins, full pairs, both pairs together, and presets that coincide with a count edge
separate pair decoding, precedence and override.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  localparam int DIGIT_W  = 4;
  localparam int QUIN_W   = DIGIT_W - 1;
  localparam logic [DIGIT_W-1:0] DIGIT_ZERO = '0;
  localparam logic [DIGIT_W-1:0] DIGIT_NINE = 4'd9;

  typedef enum logic {
    ORDER_DECIMAL = 1'b0,
    ORDER_WAVE    = 1'b1
  } order_e;

  typedef struct packed {
    logic hi;   // weight 8
    logic mid;  // weight 4
    logic lo;   // weight 2
  } quin_t;
endpackage

// File: rtl/dcnt_fall_det.sv
module dcnt_fall_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] fall
);
  logic [N-1:0] seen;

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen[i] <= 1'b0;
      else        seen[i] <= lvl[i];
    end
    assign fall[i] = seen[i] & ~lvl[i];
  end
endmodule

// File: rtl/dcnt_preset_arb.sv
module dcnt_preset_arb
  import dcnt_pkg::*;
#(
  parameter int PAIR = 2
) (
  input  logic [PAIR-1:0]    zero_req,
  input  logic [PAIR-1:0]    nine_req,
  output logic               load_en,
  output logic [DIGIT_W-1:0] load_val
);
  logic zero_all, nine_all;

  assign zero_all = &zero_req;
  assign nine_all = &nine_req;

  always_comb begin
    load_en  = zero_all | nine_all;
    load_val = nine_all ? DIGIT_NINE : DIGIT_ZERO;
  end
endmodule

// File: rtl/dcnt_div2.sv
module dcnt_div2 (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic load_bit,
  input  logic step,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (load_en) q <= load_bit;
    else if (step)    q <= ~q;
  end
endmodule

// File: rtl/dcnt_quinary.sv
module dcnt_quinary
  import dcnt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  quin_t load_val,
  input  logic  step,
  output quin_t q
);
  quin_t nxt;

  // lo toggles unless hi is set; mid follows a falling lo; hi sets after mid&lo
  always_comb begin
    nxt.lo  = q.hi ? 1'b0 : ~q.lo;
    nxt.mid = q.lo ? ~q.mid : q.mid;
    nxt.hi  = q.lo & q.mid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load_en) q <= load_val;
    else if (step)    q <= nxt;
  end
endmodule

// File: rtl/decade_divider.sv
module decade_divider
  import dcnt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_a,
  input  logic               cnt_bd,
  input  logic               sq_mode,
  input  logic               clr0_a,
  input  logic               clr0_b,
  input  logic               set9_a,
  input  logic               set9_b,
  output logic [DIGIT_W-1:0] cnt_q
);
  localparam int N_IN = 2;
  localparam int IDX_A  = 0;
  localparam int IDX_BD = 1;

  logic [N_IN-1:0]    falls;
  logic               load_en;
  logic [DIGIT_W-1:0] load_val;
  order_e             order;
  logic               tog_q;
  quin_t              quin_q;
  logic               tog_carry, quin_carry;
  logic               tog_step, quin_step;

  assign order = order_e'(sq_mode);

  dcnt_fall_det #(.N(N_IN)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({cnt_bd, cnt_a}),
    .fall (falls)
  );

  dcnt_preset_arb #(.PAIR(2)) u_arb (
    .zero_req({clr0_b, clr0_a}),
    .nine_req({set9_b, set9_a}),
    .load_en (load_en),
    .load_val(load_val)
  );

  // carries come from each stage's own source edge, so no combinational loop
  assign tog_carry  = falls[IDX_A]  & tog_q;
  assign quin_carry = falls[IDX_BD] & quin_q.hi;

  always_comb begin
    if (order == ORDER_WAVE) begin
      quin_step = falls[IDX_BD];
      tog_step  = quin_carry;
    end else begin
      tog_step  = falls[IDX_A];
      quin_step = tog_carry;
    end
  end

  dcnt_div2 u_tog (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .load_bit(load_val[0]),
    .step    (tog_step),
    .q       (tog_q)
  );

  dcnt_quinary u_quin (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .load_val(quin_t'(load_val[DIGIT_W-1:1])),
    .step    (quin_step),
    .q       (quin_q)
  );

  assign cnt_q = {quin_q, tog_q};
endmodule

// File: rtl/dcnt_checker.sv
module dcnt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cnt_a,
  input logic       cnt_bd,
  input logic       sq_mode,
  input logic       clr0_a,
  input logic       clr0_b,
  input logic       set9_a,
  input logic       set9_b,
  input logic [3:0] cnt_q
);
  logic zero_pair, nine_pair, any_preset;
  assign zero_pair  = clr0_a & clr0_b;
  assign nine_pair  = set9_a & set9_b;
  assign any_preset = zero_pair | nine_pair;

  AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_pair && !nine_pair) |=> cnt_q == 4'd0); // R1
  AST_NINE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    nine_pair |=> cnt_q == 4'd9); // R2
  AST_NINE_OVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (nine_pair && zero_pair) |=> cnt_q == 4'd9); // R3
  AST_PRESET_OVER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (any_preset && $past(cnt_a) && !cnt_a) |=> (cnt_q == 4'd0 || cnt_q == 4'd9)); // R4
  AST_LO_HELD_UNDER_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_preset && cnt_q[3]) |=> !cnt_q[1]); // R6
  AST_DIGIT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 4'd9); // R8
  AST_WAVE_BIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_preset && sq_mode && !($past(cnt_bd) && !cnt_bd && cnt_q[3])) |=> $stable(cnt_q[0])); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_preset && !($past(cnt_a) && !cnt_a) && !($past(cnt_bd) && !cnt_bd)) |=> $stable(cnt_q)); // R10
endmodule

bind decade_divider dcnt_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cnt_a  (cnt_a),
  .cnt_bd (cnt_bd),
  .sq_mode(sq_mode),
  .clr0_a (clr0_a),
  .clr0_b (clr0_b),
  .set9_a (set9_a),
  .set9_b (set9_b),
  .cnt_q  (cnt_q)
);

// File: tb/sim_decade_divider.sv
`timescale 1ns/1ps
module sim_decade_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_a = 1'b0, cnt_bd = 1'b0, sq_mode = 1'b0;
  logic       clr0_a = 1'b0, clr0_b = 1'b0, set9_a = 1'b0, set9_b = 1'b0;
  logic [3:0] cnt_q;

  int checks = 0;
  int fails  = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  // reference state: five-state index and toggle bit
  int   m_quin = 0;
  logic m_tog  = 1'b0;
  logic p_a = 1'b0, p_bd = 1'b0;

  always #5 clk = ~clk;

  decade_divider u0 (
    .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_bd(cnt_bd), .sq_mode(sq_mode),
    .clr0_a(clr0_a), .clr0_b(clr0_b), .set9_a(set9_a), .set9_b(set9_b), .cnt_q(cnt_q)
  );

  // monitor: compare each pushed expectation away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (cnt_q !== e) begin
        fails++;
        $display("FAIL %s actual=%b expected=%b", t, cnt_q, e);
      end
    end
  end

  task automatic cyc(input logic a, input logic bd, input logic md,
                     input logic [1:0] z, input logic [1:0] n, input string tag);
    logic fa, fb;
    @(negedge clk);
    cnt_a = a; cnt_bd = bd; sq_mode = md;
    clr0_a = z[0]; clr0_b = z[1]; set9_a = n[0]; set9_b = n[1];
    fa = p_a & ~a;
    fb = p_bd & ~bd;
    p_a = a; p_bd = bd;
    if (&n) begin
      m_quin = 4; m_tog = 1'b1;
    end else if (&z) begin
      m_quin = 0; m_tog = 1'b0;
    end else if (!md) begin
      if (fa) begin
        if (m_tog) m_quin = (m_quin + 1) % 5;
        m_tog = ~m_tog;
      end
    end else if (fb) begin
      if (m_quin == 4) m_tog = ~m_tog;
      m_quin = (m_quin + 1) % 5;
    end
    @(posedge clk);
    #1;
    exp_q.push_back({m_quin[2:0], m_tog});
    tag_q.push_back(tag);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 2'b00, 2'b00, "R11");

    // decimal order, cnt_bd toggling must be ignored
    for (int i = 1; i <= 12; i++) begin
      cyc(1, i[0], 0, 2'b00, 2'b00, "R7");
      cyc(0, ~i[0], 0, 2'b00, 2'b00, (i == 10) ? "R8" : "R7");
    end

    // levels held: no change
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 2'b00, 2'b00, "R10");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 2'b00, 2'b00, "R10");
    cyc(0, 0, 0, 2'b00, 2'b00, "R10");

    // single zero pin ignored, pair clears
    cyc(1, 0, 0, 2'b01, 2'b00, "R1");
    cyc(0, 0, 0, 2'b10, 2'b00, "R1");
    cyc(0, 0, 0, 2'b11, 2'b00, "R1");

    // nine pair, then wrap to zero
    cyc(0, 0, 0, 2'b00, 2'b01, "R2");
    cyc(0, 0, 0, 2'b00, 2'b11, "R2");
    cyc(1, 0, 0, 2'b00, 2'b00, "R8");
    cyc(0, 0, 0, 2'b00, 2'b00, "R8");

    // precedence
    cyc(1, 0, 0, 2'b11, 2'b11, "R3");
    cyc(0, 0, 0, 2'b00, 2'b00, "R8");

    // preset coinciding with a count edge
    cyc(1, 0, 0, 2'b00, 2'b00, "R4");
    cyc(0, 0, 0, 2'b11, 2'b00, "R4");
    cyc(1, 0, 0, 2'b00, 2'b00, "R4");
    cyc(0, 0, 0, 2'b00, 2'b11, "R4");

    // wave order, cnt_a toggling must be ignored
    cyc(0, 0, 1, 2'b11, 2'b00, "R1");
    for (int i = 1; i <= 22; i++) begin
      cyc(i[0], 1, 1, 2'b00, 2'b00, "R9");
      cyc(~i[0], 0, 1, 2'b00, 2'b00, (i % 5 == 0) ? "R6/R9" : "R5");
    end

    // nine in wave order: next edge returns stage to zero and drops bit 0
    cyc(0, 1, 1, 2'b00, 2'b11, "R2");
    cyc(0, 0, 1, 2'b00, 2'b00, "R6");

    // async reset mid-run
    cyc(0, 1, 1, 2'b00, 2'b00, "R5");
    cyc(0, 0, 1, 2'b00, 2'b00, "R5");
    wait (exp_q.size() == 0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    checks++;
    if (cnt_q !== 4'd0) begin
      fails++;
      $display("FAIL R11 actual=%b expected=%b", cnt_q, 4'd0);
    end
    m_quin = 0; m_tog = 1'b0; p_a = 1'b0; p_bd = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 2'b00, 2'b00, "R11");

    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule